// File: doc/BRIEF.md
# Fast-Clear Tile Status Controller

This block sits between a pixel producer and the memory that holds a render surface, and it makes clearing the surface lazy. The surface is cut into square tiles. A one-bit flag per tile records whether that tile is still logically cleared. A clear command raises every flag in one cycle and does not touch surface memory. Surface memory is written only when a tile is first partially written, or when software asks for a resolve pass. Until then a tile flagged as cleared reads back as the configured clear colour.

Pixel requests are reads, single-pixel writes and whole-tile writes. A single-pixel write to a flagged tile first fills all sixteen pixels of the tile with the clear colour and then performs the write. A whole-tile write overwrites every pixel, so it skips the fill. The resolve pass walks the tiles in ascending order, fills every tile that is still flagged, and then gives a one-cycle completion pulse. While the block is working through a fill, a tile write, a memory read or a resolve, it holds the pixel port not ready. Requests therefore stay in issue order. The memory side is a plain request/acknowledge port: the request and its address and data stay fixed until the acknowledge arrives.

Top module: `fcl_tile_ctrl`

## Requirements
- R1: After reset every tile is unflagged, `px_ready` is 1, and `mem_req`, `rd_valid` and `resolve_done` are 0.
- R2: An accepted `cmd_clear` flags every tile and causes no memory request.
- R3: A read (`px_op`=0) of a flagged tile returns the clear colour on `rd_valid` in the cycle after acceptance and makes no memory request.
- R4: A single-pixel write (`px_op`=1) to a flagged tile first makes 16 memory writes of the clear colour, row by row and left to right within the tile, then writes the pixel, then unflags the tile.
- R5: A single-pixel write to an unflagged tile makes exactly one memory write.
- R6: A whole-tile write (`px_op`=2 or 3) makes 16 memory writes of `px_wdata` covering the tile in the R4 order, with no clear-colour fill, and unflags the tile.
- R7: A read of an unflagged tile issues one memory read and presents `mem_rdata` on `rd_data` with `rd_valid` in the cycle after the acknowledge.
- R8: `px_ready` is 0 whenever a memory request is pending. A request holds its address, data and direction until `mem_ack`.
- R9: A resolve fills every flagged tile with the clear colour in ascending tile index (index = tile row × 16 + tile column) and unflags it. Unflagged tiles are left untouched.
- R10: `resolve_done` pulses for exactly one cycle once the last tile has been processed, and the block is idle in that cycle.
- R11: A `cmd_clear` that arrives while a resolve is running has no effect.
- R12: In the idle state `cmd_clear` takes priority over `cmd_resolve`, which takes priority over pixel requests. `px_ready` is 0 while either command is asserted.
- R13: The clear colour is the value last loaded with `cfg_load` and is used by all later cleared reads and fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load `cfg_color` as the clear colour |
| cfg_color | input | 32 | Clear colour value |
| cmd_clear | input | 1 | Flag all tiles as cleared |
| cmd_resolve | input | 1 | Start the resolve pass |
| resolve_done | output | 1 | One-cycle pulse at the end of a resolve |
| px_valid | input | 1 | Pixel request valid |
| px_ready | output | 1 | Pixel request accepted when high with `px_valid` |
| px_op | input | 2 | 0 read, 1 pixel write, 2/3 whole-tile write |
| px_x | input | 6 | Pixel column |
| px_y | input | 6 | Pixel row |
| px_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 12 | Pixel address, row × 64 + column |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data |

## Verification
With the bench memory acknowledging one cycle after a request appears, every memory access takes two cycles. A read of a flagged tile must show `rd_valid` at the first falling edge after acceptance. A memory-backed read must show it at the third. The bench counts falling edges from the accepting edge and compares the count with these figures. Write counts and address orders are compared only once `px_ready` has returned, when every acknowledged write has already landed. The resolve pulse is sampled at the edge where it first appears, and again one edge later.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  typedef enum logic [2:0] {
    FC_IDLE,
    FC_FILL,
    FC_APPLY,
    FC_TWR,
    FC_SCAN,
    FC_RFILL
  } fcl_state_e;
endpackage

// File: rtl/fcl_walk_cnt.sv
module fcl_walk_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = clr | en;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = &cnt_q;
endmodule

// File: rtl/fcl_status_bits.sv
module fcl_status_bits #(
  parameter int NT = 256,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mark_all,
  input  logic          unmark_en,
  input  logic [IW-1:0] unmark_idx,
  input  logic [IW-1:0] look_idx,
  output logic          look_cleared
);
  logic [NT-1:0] flag_q, flag_d;
  logic          upd_en;

  assign upd_en = mark_all | unmark_en;

  for (genvar gi = 0; gi < NT; gi++) begin : g_flag
    assign flag_d[gi] = mark_all ? 1'b1 :
                        ((unmark_en && (unmark_idx == IW'(gi))) ? 1'b0 : flag_q[gi]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= '0;
    else if (upd_en) flag_q <= flag_d;
  end

  assign look_cleared = flag_q[look_idx];

  a_r2_all_marked: assert property (@(posedge clk) disable iff (!rst_n)
    mark_all |=> (&flag_q));

  a_r4_unmarked: assert property (@(posedge clk) disable iff (!rst_n)
    (unmark_en && !mark_all) |=> !flag_q[$past(unmark_idx)]);
endmodule

// File: rtl/fcl_tile_ctrl.sv
module fcl_tile_ctrl
  import fcl_pkg::*;
#(
  parameter int PIX_W  = 32,
  parameter int SURF_W = 64,
  parameter int SURF_H = 64,
  parameter int TILE   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_load,
  input  logic [PIX_W-1:0]           cfg_color,
  input  logic                       cmd_clear,
  input  logic                       cmd_resolve,
  output logic                       resolve_done,
  input  logic                       px_valid,
  output logic                       px_ready,
  input  logic [1:0]                 px_op,
  input  logic [$clog2(SURF_W)-1:0]  px_x,
  input  logic [$clog2(SURF_H)-1:0]  px_y,
  input  logic [PIX_W-1:0]           px_wdata,
  output logic                       rd_valid,
  output logic [PIX_W-1:0]           rd_data,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [$clog2(SURF_W)+$clog2(SURF_H)-1:0] mem_addr,
  output logic [PIX_W-1:0]           mem_wdata,
  input  logic                       mem_ack,
  input  logic [PIX_W-1:0]           mem_rdata
);
  localparam int XW  = $clog2(SURF_W);
  localparam int YW  = $clog2(SURF_H);
  localparam int SW  = $clog2(TILE);
  localparam int PW  = 2 * SW;
  localparam int TXW = XW - SW;
  localparam int TYW = YW - SW;
  localparam int TIW = TXW + TYW;
  localparam int NT  = 1 << TIW;

  fcl_state_e        st_q, st_d;
  logic              wr_q;
  logic [XW-1:0]     x_q;
  logic [YW-1:0]     y_q;
  logic [PIX_W-1:0]  d_q, cc_q, rd_data_q;
  logic              rd_valid_q, done_q;

  logic              acc_clear, res_start, acc_px, rd_cc, rd_mem, done_d;
  logic              unmark_en, pc_en, tc_en, rd_en;
  logic [TIW-1:0]    unmark_idx, look_idx, in_tile, reg_tile, walk_tile;
  logic              look_cleared;
  logic [PW-1:0]     pc;
  logic              pc_last;
  logic [TIW-1:0]    tc;
  logic              tc_last;
  logic [XW+YW-1:0]  fill_addr;

  assign in_tile   = {px_y[YW-1:SW], px_x[XW-1:SW]};
  assign reg_tile  = {y_q[YW-1:SW], x_q[XW-1:SW]};
  assign look_idx  = (st_q == FC_SCAN) ? tc : in_tile;
  assign walk_tile = (st_q == FC_RFILL) ? tc : reg_tile;
  assign fill_addr = {walk_tile[TIW-1:TXW], pc[PW-1:SW], walk_tile[TXW-1:0], pc[SW-1:0]};

  fcl_status_bits #(.NT(NT), .IW(TIW)) i_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .mark_all     (acc_clear),
    .unmark_en    (unmark_en),
    .unmark_idx   (unmark_idx),
    .look_idx     (look_idx),
    .look_cleared (look_cleared)
  );

  fcl_walk_cnt #(.W(PW)) i_pix_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .en    (pc_en),
    .cnt   (pc),
    .last  (pc_last)
  );

  fcl_walk_cnt #(.W(TIW)) i_tile_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (res_start),
    .en    (tc_en),
    .cnt   (tc),
    .last  (tc_last)
  );

  assign px_ready = (st_q == FC_IDLE) && !cmd_clear && !cmd_resolve;

  always_comb begin
    st_d       = st_q;
    acc_clear  = 1'b0;
    res_start  = 1'b0;
    acc_px     = 1'b0;
    rd_cc      = 1'b0;
    rd_mem     = 1'b0;
    done_d     = 1'b0;
    unmark_en  = 1'b0;
    unmark_idx = reg_tile;
    pc_en      = 1'b0;
    tc_en      = 1'b0;
    case (st_q)
      FC_IDLE: begin
        if (cmd_clear) begin
          acc_clear = 1'b1;
        end else if (cmd_resolve) begin
          res_start = 1'b1;
          st_d      = FC_SCAN;
        end else if (px_valid) begin
          acc_px = 1'b1;
          if (px_op[1]) begin
            st_d       = FC_TWR;
            unmark_en  = 1'b1;
            unmark_idx = in_tile;
          end else if (look_cleared) begin
            if (px_op[0]) st_d  = FC_FILL;
            else          rd_cc = 1'b1;
          end else begin
            st_d = FC_APPLY;
          end
        end
      end
      FC_FILL: begin
        if (mem_ack) begin
          pc_en = 1'b1;
          if (pc_last) begin
            st_d      = FC_APPLY;
            unmark_en = 1'b1;
          end
        end
      end
      FC_APPLY: begin
        if (mem_ack) begin
          st_d   = FC_IDLE;
          rd_mem = !wr_q;
        end
      end
      FC_TWR: begin
        if (mem_ack) begin
          pc_en = 1'b1;
          if (pc_last) st_d = FC_IDLE;
        end
      end
      FC_SCAN: begin
        if (look_cleared) begin
          st_d = FC_RFILL;
        end else begin
          tc_en = 1'b1;
          if (tc_last) begin
            st_d   = FC_IDLE;
            done_d = 1'b1;
          end
        end
      end
      FC_RFILL: begin
        if (mem_ack) begin
          pc_en = 1'b1;
          if (pc_last) begin
            unmark_en  = 1'b1;
            unmark_idx = tc;
            tc_en      = 1'b1;
            if (tc_last) begin
              st_d   = FC_IDLE;
              done_d = 1'b1;
            end else begin
              st_d = FC_SCAN;
            end
          end
        end
      end
      default: st_d = FC_IDLE;
    endcase
  end

  assign rd_en = rd_cc | rd_mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= FC_IDLE;
      rd_valid_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      rd_valid_q <= rd_en;
      done_q     <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      x_q  <= '0;
      y_q  <= '0;
      d_q  <= '0;
    end else if (acc_px) begin
      wr_q <= px_op[0];
      x_q  <= px_x;
      y_q  <= px_y;
      d_q  <= px_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cc_q <= '0;
    else if (cfg_load) cc_q <= cfg_color;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data_q <= '0;
    else if (rd_en) rd_data_q <= rd_cc ? cc_q : mem_rdata;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b1;
    mem_addr  = fill_addr;
    mem_wdata = cc_q;
    case (st_q)
      FC_FILL, FC_RFILL: mem_req = 1'b1;
      FC_TWR: begin
        mem_req   = 1'b1;
        mem_wdata = d_q;
      end
      FC_APPLY: begin
        mem_req   = 1'b1;
        mem_we    = wr_q;
        mem_addr  = {y_q, x_q};
        mem_wdata = d_q;
      end
      default: mem_req = 1'b0;
    endcase
  end

  assign rd_valid     = rd_valid_q;
  assign rd_data      = rd_data_q;
  assign resolve_done = done_q;

  a_r2_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear |=> !mem_req);

  a_r3_cc_read_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cc |=> (!mem_req && rd_valid));

  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !px_ready);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_done |=> !resolve_done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_done |-> (st_q == FC_IDLE && !mem_req));
endmodule

// File: tb/test_fcl_tile_ctrl.sv
`timescale 1ns/1ps
module test_fcl_tile_ctrl;
  localparam int W = 64, H = 64, T = 4, NPIX = W * H, NT = (W / T) * (H / T);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cfg_load, cmd_clear, cmd_resolve, resolve_done;
  logic [31:0] cfg_color, px_wdata, rd_data, mem_wdata, mem_rdata;
  logic        px_valid, px_ready, rd_valid, mem_req, mem_we, mem_ack;
  logic [1:0]  px_op;
  logic [5:0]  px_x, px_y;
  logic [11:0] mem_addr;

  fcl_tile_ctrl i_fcl_tile_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_color(cfg_color),
    .cmd_clear(cmd_clear), .cmd_resolve(cmd_resolve), .resolve_done(resolve_done),
    .px_valid(px_valid), .px_ready(px_ready), .px_op(px_op), .px_x(px_x), .px_y(px_y),
    .px_wdata(px_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem    [NPIX];
  logic [31:0] refmem [NPIX];
  bit          refclr [NT];
  logic [31:0] cc;
  int total = 0, bad = 0, wr_cnt = 0, req_cyc = 0;
  int wr_q[$];
  bit finished = 1'b0;

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      for (int i = 0; i < NPIX; i++) mem[i] <= 32'hA500_0000 | 32'(i);
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack && mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        wr_q.push_back(int'(mem_addr));
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (mem_req) req_cyc++;
      if (mem_req && px_ready) chk(1'b0, "R8 ready while request pending", 32'(px_ready), 0);
    end
  end

  function automatic int tidx(int x, int y);
    return (y / T) * (W / T) + x / T;
  endfunction

  function automatic int faddr(int t, int p);
    return ((t / (W / T)) * T + p / T) * W + (t % (W / T)) * T + p % T;
  endfunction

  task automatic idle_wait();
    @(negedge clk);
    while (!px_ready) @(negedge clk);
  endtask

  task automatic issue(input int op, input int x, input int y, input logic [31:0] d);
    @(negedge clk);
    px_valid = 1'b1; px_op = 2'(op); px_x = 6'(x); px_y = 6'(y); px_wdata = d;
    while (!px_ready) @(negedge clk);
    @(posedge clk);
    #1 px_valid = 1'b0;
  endtask

  task automatic cfg(input logic [31:0] c);
    @(negedge clk);
    cfg_load = 1'b1; cfg_color = c;
    @(posedge clk);
    #1 cfg_load = 1'b0;
    cc = c;
  endtask

  task automatic model_write(input int x, input int y, input logic [31:0] d, input string req);
    int t, n0, ex, mis;
    bit was;
    t = tidx(x, y); was = refclr[t]; n0 = wr_cnt;
    ex = was ? 17 : 1;
    idle_wait();
    chk(wr_cnt - n0 == ex, req, 32'(wr_cnt - n0), 32'(ex));
    mis = 0;
    if (wr_q.size() == ex) begin
      if (was) for (int p = 0; p < 16; p++) if (wr_q[p] != faddr(t, p)) mis++;
      if (wr_q[ex-1] != y * W + x) mis++;
    end else mis = 1;
    chk(mis == 0, {req, " write order"}, 32'(mis), 0);
    if (was) for (int p = 0; p < 16; p++) refmem[faddr(t, p)] = cc;
    refclr[t] = 1'b0;
    refmem[y * W + x] = d;
  endtask

  task automatic wr_pix(input int x, input int y, input logic [31:0] d, input string req);
    wr_q.delete();
    issue(1, x, y, d);
    model_write(x, y, d, req);
  endtask

  task automatic rd_pix(input int x, input int y, input string req);
    int t, n, r0;
    bit was;
    logic [31:0] exp;
    t = tidx(x, y); was = refclr[t];
    exp = was ? cc : refmem[y * W + x];
    r0 = req_cyc;
    issue(0, x, y, 32'h0);
    n = 0;
    do begin @(negedge clk); n++; end while (!rd_valid && n < 10);
    chk(rd_valid && rd_data == exp, {req, " read data"}, rd_data, exp);
    chk(n == (was ? 1 : 3), {req, " read latency"}, 32'(n), was ? 1 : 3);
    if (was) chk(req_cyc == r0, {req, " R3 no memory access"}, 32'(req_cyc - r0), 0);
    idle_wait();
  endtask

  task automatic tile_wr(input int tx, input int ty, input logic [31:0] d, input string req);
    int t, n0, mis;
    t = ty * (W / T) + tx;
    wr_q.delete(); n0 = wr_cnt;
    issue(2, tx * T + 1, ty * T + 2, d);
    idle_wait();
    chk(wr_cnt - n0 == 16, req, 32'(wr_cnt - n0), 16);
    mis = 0;
    if (wr_q.size() == 16) begin
      for (int p = 0; p < 16; p++) if (wr_q[p] != faddr(t, p)) mis++;
    end else mis = 1;
    chk(mis == 0, {req, " tile order"}, 32'(mis), 0);
    for (int p = 0; p < 16; p++) refmem[faddr(t, p)] = d;
    refclr[t] = 1'b0;
  endtask

  task automatic do_clear();
    int r0, n0;
    @(negedge clk);
    cmd_clear = 1'b1;
    @(posedge clk);
    #1 cmd_clear = 1'b0;
    r0 = req_cyc; n0 = wr_cnt;
    repeat (3) @(negedge clk);
    chk(req_cyc == r0 && wr_cnt == n0, "R2 clear touches no memory", 32'(req_cyc - r0), 0);
    for (int t = 0; t < NT; t++) refclr[t] = 1'b1;
  endtask

  task automatic do_resolve(input bit poke_clear);
    int n0, ncl, cyc, k, mis;
    int exp_q[$];
    ncl = 0;
    for (int t = 0; t < NT; t++)
      if (refclr[t]) begin
        ncl++;
        for (int p = 0; p < 16; p++) exp_q.push_back(faddr(t, p));
      end
    wr_q.delete(); n0 = wr_cnt;
    @(negedge clk);
    cmd_resolve = 1'b1;
    @(posedge clk);
    #1 cmd_resolve = 1'b0;
    if (poke_clear) begin
      repeat (5) @(negedge clk);
      cmd_clear = 1'b1;
      @(posedge clk);
      #1 cmd_clear = 1'b0;
    end
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!resolve_done && cyc < 40000);
    chk(resolve_done, "R10 done pulse seen", 32'(resolve_done), 1);
    chk(wr_cnt - n0 == 16 * ncl, "R9 resolve write count", 32'(wr_cnt - n0), 32'(16 * ncl));
    mis = 0;
    if (wr_q.size() == exp_q.size()) begin
      for (k = 0; k < exp_q.size(); k++) if (wr_q[k] != exp_q[k]) mis++;
    end else mis = 1;
    chk(mis == 0, "R9 resolve order", 32'(mis), 0);
    chk(px_ready, "R10 idle at done", 32'(px_ready), 1);
    @(negedge clk);
    chk(!resolve_done, "R10 done is one cycle", 32'(resolve_done), 0);
    for (int t = 0; t < NT; t++)
      if (refclr[t]) begin
        for (int p = 0; p < 16; p++) refmem[faddr(t, p)] = cc;
        refclr[t] = 1'b0;
      end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int mis;
    rst_n = 1'b0; cfg_load = 1'b0; cfg_color = '0; cmd_clear = 1'b0; cmd_resolve = 1'b0;
    px_valid = 1'b0; px_op = '0; px_x = '0; px_y = '0; px_wdata = '0; cc = '0;
    for (int i = 0; i < NPIX; i++) refmem[i] = 32'hA500_0000 | 32'(i);
    for (int t = 0; t < NT; t++) refclr[t] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(px_ready, "R1 ready after reset", 32'(px_ready), 1);
    chk(!mem_req && !rd_valid && !resolve_done, "R1 outputs idle after reset",
        32'({mem_req, rd_valid, resolve_done}), 0);
    rd_pix(7, 9, "R1 R7");

    cfg(32'hC1EA_0001);
    do_clear();
    rd_pix(0, 0, "R3");
    rd_pix(63, 63, "R3 R13");

    wr_pix(5, 2, 32'h1111_0001, "R4");
    rd_pix(5, 2, "R7");
    rd_pix(4, 0, "R4 fill");
    wr_pix(6, 3, 32'h2222_0002, "R5");
    tile_wr(3, 3, 32'h3333_0003, "R6");
    rd_pix(13, 14, "R6");

    // R12: clear and a pixel write presented together; clear wins
    wr_q.delete();
    @(negedge clk);
    cmd_clear = 1'b1; px_valid = 1'b1; px_op = 2'd1; px_x = 6'd5; px_y = 6'd2; px_wdata = 32'h4444_0004;
    #0.5 chk(!px_ready, "R12 ready low while command", 32'(px_ready), 0);
    @(posedge clk);
    #1 cmd_clear = 1'b0;
    for (int t = 0; t < NT; t++) refclr[t] = 1'b1;
    while (!px_ready) @(negedge clk);
    @(posedge clk);
    #1 px_valid = 1'b0;
    model_write(5, 2, 32'h4444_0004, "R12");

    cfg(32'h5EED_0002);
    rd_pix(40, 40, "R13");
    tile_wr(0, 15, 32'h6666_0006, "R6");

    do_resolve(1'b1);
    rd_pix(2, 61, "R11");
    rd_pix(0, 0, "R9");
    mis = 0;
    for (int i = 0; i < NPIX; i++) if (mem[i] !== refmem[i]) mis++;
    chk(mis == 0, "R9 surface matches model", 32'(mis), 0);

    do_resolve(1'b0);
    rd_pix(33, 17, "R9");

    summary();
    $finish;
  end
endmodule